// File: doc/BRIEF.md
# Accelerator Control and Status Unit

This unit sits in front of a public-key arithmetic engine. It decides whether a software start request may launch a computation, tracks the engine's busy period, and reports the outcome through a small set of status flags. A start is accepted only after the unit has come up cleanly. Coming up cleanly means the enable has been held and the random source has reported healthy output for a fixed settle time. The unit can also be in a restricted mode that is captured when the enable rises. In that mode only one operation code may run.

A legal operation keeps the unit busy until the engine pulses its done line. An operation code that is unknown, or that the restricted mode forbids, still makes the unit busy, but only for a short fixed window. The unit then gives up by itself and raises a sticky operation-error flag. Touching the operand RAM while busy, or touching an unmapped address, raises its own sticky error flag. Each error flag and the end-of-operation flag has its own clear strobe.

Top module: `accel_ctl_status`

## Requirements
- R1: While reset is asserted and right after it, busy_o, end_op_o, init_ok_o, limited_o, ram_err_o, addr_err_o and op_err_o are all 0.
- R2: init_ok_o becomes 1 after INIT_CYCLES (default 8) consecutive clock edges with enable_i and rng_ok_i both high, and not before. It returns to 0 one edge after either input goes low.
- R3: While init_ok_o is 0, a start request has no effect and busy_o stays 0.
- R4: limited_o takes the value of limited_cfg_i at the clock edge where enable_i is first seen high after being low, and holds that value at every other edge.
- R5: A start with a legal opcode, while idle and initialized, sets busy_o at that edge. busy_o stays 1 until the edge that samples core_done_i high. With the default mask, codes 0x00-0x0F and 0x20-0x27 of the 6-bit opcode are legal.
- R6: A start with an illegal opcode keeps busy_o at 1 for exactly ABORT_CYCLES (default 4) cycles, and then busy_o returns to 0 without core_done_i. When limited_o is 1, every code other than 0x26 counts as illegal.
- R7: Accepting an illegal opcode sets op_err_o at the same edge as busy_o rises.
- R8: end_op_o is set at the edge where busy_o falls. It is cleared by clr_end_i or by an accepted start. Setting wins over clearing.
- R9: A start request while busy_o is 1 is ignored. It neither restarts the operation, nor shortens or lengthens it, nor sets op_err_o.
- R10: ram_acc_i high while busy_o is 1 sets ram_err_o at the next edge. ram_acc_i while idle leaves ram_err_o unchanged.
- R11: unmapped_acc_i high sets addr_err_o at the next edge, whatever the busy state.
- R12: ram_err_o, addr_err_o and op_err_o stay set until their own clear input is 1. A clear in the same cycle as a new error event leaves the flag set. A clear never affects another flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Unit enable level |
| rng_ok_i | input | 1 | Random source reports valid output |
| limited_cfg_i | input | 1 | Restricted-mode setting, captured when enable rises |
| start_i | input | 1 | Start request strobe |
| opcode_i | input | OPC_W | Operation code presented with start |
| core_done_i | input | 1 | Engine completion pulse |
| ram_acc_i | input | 1 | Bus access to operand RAM |
| unmapped_acc_i | input | 1 | Bus access to an unmapped address |
| clr_ram_err_i | input | 1 | Clear strobe for ram_err_o |
| clr_addr_err_i | input | 1 | Clear strobe for addr_err_o |
| clr_op_err_i | input | 1 | Clear strobe for op_err_o |
| clr_end_i | input | 1 | Clear strobe for end_op_o |
| busy_o | output | 1 | Operation in progress |
| end_op_o | output | 1 | Operation finished |
| init_ok_o | output | 1 | Initialization complete |
| limited_o | output | 1 | Restricted mode active |
| ram_err_o | output | 1 | Sticky RAM conflict error |
| addr_err_o | output | 1 | Sticky unmapped address error |
| op_err_o | output | 1 | Sticky illegal operation error |

## Verification
The bench measures the abort window cycle by cycle. A counter that is off by one would show busy for three or five cycles instead of four. It also sends codes on both sides of each legal-range boundary, so a mask decode that is shifted would run an illegal code or abort a legal one. Restricted mode is exercised with a code that is legal in normal mode, so a design that ignores the mode would run it instead of aborting. Clears that arrive in the same cycle as a new error event are checked to leave the flag set, and a start issued mid-operation must change nothing. A design that lets clear win, or that re-decodes a late start, would drop a flag or raise a false error.

// File: rtl/acs_pkg.sv
package acs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ABORT = 2'd2
  } acs_state_e;

  localparam int unsigned ERR_N    = 3;
  localparam int unsigned ERR_RAM  = 0;
  localparam int unsigned ERR_ADDR = 1;
  localparam int unsigned ERR_OP   = 2;
endpackage

// File: rtl/acs_init.sv
module acs_init #(
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic rng_ok_i,
  input  logic limited_cfg_i,
  output logic init_ok_o,
  output logic limited_o
);
  localparam int unsigned CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(INIT_CYCLES);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          en_q;
  logic          lim_q, lim_n;

  always_comb begin
    cnt_n = cnt_q;
    if (!(enable_i && rng_ok_i)) begin
      cnt_n = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_n = cnt_q + 1'b1;
    end
    lim_n = lim_q;
    if (enable_i && !en_q) begin
      lim_n = limited_cfg_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      lim_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      en_q  <= enable_i;
      lim_q <= lim_n;
    end
  end

  assign init_ok_o = (cnt_q == CNT_MAX);
  assign limited_o = lim_q;
endmodule

// File: rtl/acs_seq.sv
module acs_seq
  import acs_pkg::*;
#(
  parameter int unsigned OPC_W        = 6,
  parameter logic [(1<<OPC_W)-1:0] LEGAL_MASK = 64'h0000_00FF_0000_FFFF,
  parameter int unsigned LIMITED_OP   = 'h26,
  parameter int unsigned ABORT_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             init_ok_i,
  input  logic             limited_i,
  input  logic             core_done_i,
  output logic             busy_o,
  output logic             accept_o,
  output logic             illegal_o,
  output logic             done_o
);
  localparam int unsigned AW = (ABORT_CYCLES > 1) ? $clog2(ABORT_CYCLES) : 1;
  localparam logic [AW-1:0] ABORT_LOAD = AW'(ABORT_CYCLES - 1);
  localparam logic [OPC_W-1:0] LIM_CODE = OPC_W'(LIMITED_OP);

  acs_state_e    st_q, st_n;
  logic [AW-1:0] cnt_q, cnt_n;
  logic          legal;

  assign legal     = LEGAL_MASK[opcode_i] && (!limited_i || (opcode_i == LIM_CODE));
  assign accept_o  = start_i && init_ok_i && (st_q == ST_IDLE);
  assign illegal_o = accept_o && !legal;
  assign done_o    = ((st_q == ST_RUN) && core_done_i) ||
                     ((st_q == ST_ABORT) && (cnt_q == '0));
  assign busy_o    = (st_q != ST_IDLE);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (accept_o) begin
          if (legal) begin
            st_n = ST_RUN;
          end else begin
            st_n  = ST_ABORT;
            cnt_n = ABORT_LOAD;
          end
        end
      end
      ST_RUN: begin
        if (core_done_i) st_n = ST_IDLE;
      end
      ST_ABORT: begin
        if (cnt_q == '0) st_n = ST_IDLE;
        else             cnt_n = cnt_q - 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/acs_flags.sv
module acs_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_n;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_n[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_n[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/accel_ctl_status.sv
module accel_ctl_status
  import acs_pkg::*;
#(
  parameter int unsigned OPC_W        = 6,
  parameter logic [(1<<OPC_W)-1:0] LEGAL_MASK = 64'h0000_00FF_0000_FFFF,
  parameter int unsigned LIMITED_OP   = 'h26,
  parameter int unsigned ABORT_CYCLES = 4,
  parameter int unsigned INIT_CYCLES  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             rng_ok_i,
  input  logic             limited_cfg_i,
  input  logic             start_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             core_done_i,
  input  logic             ram_acc_i,
  input  logic             unmapped_acc_i,
  input  logic             clr_ram_err_i,
  input  logic             clr_addr_err_i,
  input  logic             clr_op_err_i,
  input  logic             clr_end_i,
  output logic             busy_o,
  output logic             end_op_o,
  output logic             init_ok_o,
  output logic             limited_o,
  output logic             ram_err_o,
  output logic             addr_err_o,
  output logic             op_err_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             accept, illegal, done;
  logic             end_q, end_n;
  logic [ERR_N-1:0] err_set, err_clr, err_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acs_init #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .enable_i      (enable_i),
    .rng_ok_i      (rng_ok_i),
    .limited_cfg_i (limited_cfg_i),
    .init_ok_o     (init_ok_o),
    .limited_o     (limited_o)
  );

  acs_seq #(
    .OPC_W        (OPC_W),
    .LEGAL_MASK   (LEGAL_MASK),
    .LIMITED_OP   (LIMITED_OP),
    .ABORT_CYCLES (ABORT_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .opcode_i    (opcode_i),
    .init_ok_i   (init_ok_o),
    .limited_i   (limited_o),
    .core_done_i (core_done_i),
    .busy_o      (busy_o),
    .accept_o    (accept),
    .illegal_o   (illegal),
    .done_o      (done)
  );

  always_comb begin
    err_set           = '0;
    err_set[ERR_RAM]  = ram_acc_i && busy_o;
    err_set[ERR_ADDR] = unmapped_acc_i;
    err_set[ERR_OP]   = illegal;
    err_clr           = '0;
    err_clr[ERR_RAM]  = clr_ram_err_i;
    err_clr[ERR_ADDR] = clr_addr_err_i;
    err_clr[ERR_OP]   = clr_op_err_i;
  end

  acs_flags #(.N(ERR_N)) u_flags (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (err_set),
    .clr_i  (err_clr),
    .flag_o (err_flags)
  );

  always_comb begin
    end_n = end_q;
    if (done)                        end_n = 1'b1;
    else if (clr_end_i || accept)    end_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) end_q <= 1'b0;
    else            end_q <= end_n;
  end

  assign end_op_o   = end_q;
  assign ram_err_o  = err_flags[ERR_RAM];
  assign addr_err_o = err_flags[ERR_ADDR];
  assign op_err_o   = err_flags[ERR_OP];
endmodule

// File: rtl/acs_chk.sv
module acs_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic ram_acc_i,
  input logic unmapped_acc_i,
  input logic clr_ram_err_i,
  input logic clr_op_err_i,
  input logic busy_o,
  input logic end_op_o,
  input logic init_ok_o,
  input logic ram_err_o,
  input logic addr_err_o,
  input logic op_err_o
);
  // R3
  no_start_uninit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_ok_o && start_i && !busy_o) |=> !busy_o);

  // R5
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i && init_ok_o));

  // R8
  end_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> end_op_o);

  // R10
  ram_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ram_acc_i) |=> ram_err_o);

  // R11
  unmapped_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_acc_i |=> addr_err_o);

  // R12
  ram_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_err_o && !clr_ram_err_i) |=> ram_err_o);

  // R12
  op_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_err_o && !clr_op_err_i) |=> op_err_o);

  // R11
  addr_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_err_o && !unmapped_acc_i) |=> !addr_err_o);
endmodule

bind accel_ctl_status acs_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .ram_acc_i      (ram_acc_i),
  .unmapped_acc_i (unmapped_acc_i),
  .clr_ram_err_i  (clr_ram_err_i),
  .clr_op_err_i   (clr_op_err_i),
  .busy_o         (busy_o),
  .end_op_o       (end_op_o),
  .init_ok_o      (init_ok_o),
  .ram_err_o      (ram_err_o),
  .addr_err_o     (addr_err_o),
  .op_err_o       (op_err_o)
);

// File: tb/tb_accel_ctl_status.sv
`timescale 1ns/1ps
module tb_accel_ctl_status;
  logic clk = 1'b0;
  logic rst_n;
  logic enable_i, rng_ok_i, limited_cfg_i, start_i, core_done_i;
  logic [5:0] opcode_i;
  logic ram_acc_i, unmapped_acc_i;
  logic clr_ram_err_i, clr_addr_err_i, clr_op_err_i, clr_end_i;
  logic busy_o, end_op_o, init_ok_o, limited_o, ram_err_o, addr_err_o, op_err_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  accel_ctl_status dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .rng_ok_i(rng_ok_i),
    .limited_cfg_i(limited_cfg_i), .start_i(start_i), .opcode_i(opcode_i),
    .core_done_i(core_done_i), .ram_acc_i(ram_acc_i), .unmapped_acc_i(unmapped_acc_i),
    .clr_ram_err_i(clr_ram_err_i), .clr_addr_err_i(clr_addr_err_i),
    .clr_op_err_i(clr_op_err_i), .clr_end_i(clr_end_i),
    .busy_o(busy_o), .end_op_o(end_op_o), .init_ok_o(init_ok_o),
    .limited_o(limited_o), .ram_err_o(ram_err_o), .addr_err_o(addr_err_o),
    .op_err_o(op_err_o)
  );

  // bit 6: opcode expected legal in normal mode; bits 5:0: opcode
  localparam logic [6:0] VEC [9] = '{
    {1'b1, 6'h00}, {1'b1, 6'h0F}, {1'b0, 6'h10}, {1'b0, 6'h1F},
    {1'b1, 6'h20}, {1'b1, 6'h26}, {1'b1, 6'h27}, {1'b0, 6'h28},
    {1'b0, 6'h3F}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [5:0] op);
    start_i  = 1'b1;
    opcode_i = op;
    tick();
    start_i  = 1'b0;
  endtask

  // counts busy cycles following an accepted start (start edge already passed)
  task automatic busy_len(output int n);
    n = 0;
    while (busy_o && n < 20) begin
      n++;
      tick();
    end
  endtask

  task automatic run_legal(input logic [5:0] op, input string req);
    pulse_start(op);
    check(req, busy_o, 1);
    check("R8 end cleared by start", end_op_o, 0);
    tick(); tick(); tick();
    check(req, busy_o, 1);
    core_done_i = 1'b1;
    tick();
    core_done_i = 1'b0;
    check(req, busy_o, 0);
    check("R8 end set", end_op_o, 1);
    check("R7 no op error on legal", op_err_o, 0);
  endtask

  task automatic run_illegal(input logic [5:0] op, input string req);
    int n;
    pulse_start(op);
    check("R7 op error on accept", op_err_o, 1);
    busy_len(n);
    check(req, n, 4);
    check("R8 end set after abort", end_op_o, 1);
    clr_op_err_i = 1'b1;
    tick();
    clr_op_err_i = 1'b0;
    check("R12 op error cleared", op_err_o, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    {enable_i, rng_ok_i, limited_cfg_i, start_i, core_done_i} = '0;
    opcode_i = '0;
    {ram_acc_i, unmapped_acc_i, clr_ram_err_i, clr_addr_err_i, clr_op_err_i, clr_end_i} = '0;
    repeat (3) tick();
    // R1
    check("R1 reset outputs", {busy_o, end_op_o, init_ok_o, limited_o, ram_err_o, addr_err_o, op_err_o}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 after reset", {busy_o, end_op_o, init_ok_o, limited_o, ram_err_o, addr_err_o, op_err_o}, 0);

    // R3: start with unit disabled
    pulse_start(6'h01);
    check("R3 start before init", busy_o, 0);

    // R2: random source unhealthy keeps init low
    enable_i = 1'b1;
    repeat (12) tick();
    check("R2 rng bad", init_ok_o, 0);
    pulse_start(6'h01);
    check("R3 start while rng bad", busy_o, 0);
    rng_ok_i = 1'b1;
    repeat (7) tick();
    check("R2 one edge early", init_ok_o, 0);
    tick();
    check("R2 init after 8", init_ok_o, 1);
    check("R4 normal mode", limited_o, 0);

    // R5/R6 table walk
    for (int i = 0; i < 9; i++) begin
      if (VEC[i][6]) run_legal(VEC[i][5:0], "R5 legal opcode runs");
      else           run_illegal(VEC[i][5:0], "R6 illegal abort length");
    end

    // R9: start while busy ignored
    pulse_start(6'h02);
    pulse_start(6'h3F);
    check("R9 no op error from late start", op_err_o, 0);
    // R10: RAM access while busy
    ram_acc_i = 1'b1;
    tick();
    ram_acc_i = 1'b0;
    check("R10 ram error while busy", ram_err_o, 1);
    // R12: clear together with new event keeps flag
    ram_acc_i = 1'b1; clr_ram_err_i = 1'b1;
    tick();
    ram_acc_i = 1'b0; clr_ram_err_i = 1'b0;
    check("R12 set beats clear", ram_err_o, 1);
    repeat (6) tick();
    check("R9 still busy", busy_o, 1);
    core_done_i = 1'b1;
    tick();
    core_done_i = 1'b0;
    check("R9 ends on done", busy_o, 0);
    check("R9 no op error", op_err_o, 0);

    // R8: clear of end flag
    clr_end_i = 1'b1;
    tick();
    clr_end_i = 1'b0;
    check("R8 end cleared", end_op_o, 0);

    // R11 and R12 isolation
    unmapped_acc_i = 1'b1;
    tick();
    unmapped_acc_i = 1'b0;
    check("R11 address error", addr_err_o, 1);
    clr_ram_err_i = 1'b1;
    tick();
    clr_ram_err_i = 1'b0;
    check("R12 ram cleared", ram_err_o, 0);
    check("R12 addr untouched", addr_err_o, 1);
    // R10: idle access has no effect
    ram_acc_i = 1'b1;
    tick();
    ram_acc_i = 1'b0;
    tick();
    check("R10 idle access ignored", ram_err_o, 0);
    clr_addr_err_i = 1'b1;
    tick();
    clr_addr_err_i = 1'b0;
    check("R12 addr cleared", addr_err_o, 0);

    // R4/R6: restricted mode
    enable_i = 1'b0;
    tick();
    check("R2 drops with enable", init_ok_o, 0);
    limited_cfg_i = 1'b1;
    enable_i = 1'b1;
    tick();
    check("R4 captured on enable rise", limited_o, 1);
    limited_cfg_i = 1'b0;
    repeat (9) tick();
    check("R4 held", limited_o, 1);
    check("R2 re-init", init_ok_o, 1);
    run_illegal(6'h05, "R6 restricted abort length");
    run_legal(6'h26, "R5 restricted code runs");

    // R6: abort clears without done
    pulse_start(6'h3F);
    busy_len(n);
    check("R6 abort self-terminates", n, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule